// File: doc/BRIEF.md
# Saturating Wiper Register Controller

This block keeps the volatile position codes of a set of digital potentiometer wipers and carries out a 4-bit command on them each time a command strobe is accepted. Commands can load a code directly, step a wiper up or down by one, double or halve it by a one-bit shift, or apply a step to every channel at once. Every step clamps at all zeros or all ones instead of wrapping. Commands can also copy a wiper to its stored copy, write a data byte to a stored copy, restore wipers from their stored copies, and latch either copy into a readback register.

The stored (nonvolatile) copies live outside the block. The block reads all of them at once on a flat bus and writes one of them through a single-cycle write strobe. An active-low preset pin holds every wiper at midscale while it is low. On its release the wipers reload from their stored copies. An active-low write-protect pin blocks every command that would change a wiper or a stored copy, except the restore and read commands. After reset the block loads the stored copies into the wipers before it reports them valid.

Top module: `wiper_ctrl`

## Requirements
- R1: While rst_ni is low, wiper_o, rdback_o and valid_o are all zero. At the first clock edge after release, each channel c loads nv_rdata_i[c*W +: W] and valid_o rises and stays high. Commands are ignored until valid_o is high.
- R2: Opcode 11 with an accepted strobe loads cmd_data_i into the addressed wiper. The result is visible after that clock edge.
- R3: Opcode 14 increments and opcode 6 decrements the addressed wiper by one. An increment at all ones leaves the wiper at all ones, and a decrement at zero leaves it at zero.
- R4: Opcode 12 shifts the addressed wiper left with a 1 entering the LSB. If the MSB was already set, the result is all ones. Opcode 4 shifts it right with a 0 entering the MSB, so zero stays zero.
- R5: Opcodes 15, 7, 13 and 5 apply increment, decrement, left shift and right shift to every channel, whatever the value of cmd_addr_i.
- R6: The step and shift opcodes (4, 5, 6, 7, 12, 13, 14, 15) ignore cmd_data_i.
- R7: Opcode 2 (wiper to store) and opcode 3 (data to store) raise nv_we_o in the cycle the command is accepted. In that cycle nv_waddr_o is the channel and nv_wdata_o is the current wiper (opcode 2) or cmd_data_i (opcode 3). No other case raises nv_we_o.
- R8: Opcode 1 loads the addressed wiper from its stored copy. Opcode 8 loads every wiper from its stored copy.
- R9: Opcode 9 latches the addressed stored copy and opcode 10 latches the addressed wiper into rdback_o after the edge. All other commands leave rdback_o unchanged.
- R10: Address 0 selects channel 0 and address 1 selects channel 1. A single-channel opcode with any other address changes no wiper, stored copy or readback value. Opcode 0 does nothing.
- R11: While preset_ni is low, every wiper is forced to midscale (MSB only set) at each edge and commands are ignored. At the first edge with preset_ni high after a low, every wiper reloads its stored copy and any command in that cycle is ignored.
- R12: While wp_ni is low, opcodes 2, 3, 4, 5, 6, 7, 11, 12, 13, 14 and 15 have no effect. Opcodes 0, 1, 8, 9 and 10 still act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, sampled each edge |
| cmd_op_i | input | 4 | Opcode |
| cmd_addr_i | input | AW | Channel address |
| cmd_data_i | input | W | Data byte |
| nv_rdata_i | input | NCH*W | All stored copies, channel c at bits c*W +: W |
| preset_ni | input | 1 | Active-low preset pin |
| wp_ni | input | 1 | Active-low write protect |
| nv_we_o | output | 1 | Stored copy write strobe |
| nv_waddr_o | output | CW | Stored copy write channel |
| nv_wdata_o | output | W | Stored copy write data |
| wiper_o | output | NCH*W | Wiper codes, channel c at bits c*W +: W |
| rdback_o | output | W | Readback register |
| valid_o | output | 1 | Wipers loaded after reset |

## Verification
The assertions assume that the external store writes a value only on nv_we_o and that its read bus is stable around each edge. The bench meets this by writing its store model just after the edge, one time unit later. The assertions also assume that the preset and protect pins are already synchronous to clk_i. The bench changes them only on the falling edge, together with the command fields. The stimulus holds the address within 0..3, so both valid channels and out-of-range addresses occur often. Long random runs mix preset pulses and protected cycles with all sixteen opcodes.

// File: rtl/wpot_pkg.sv
package wpot_pkg;
  typedef enum logic [3:0] {
    OP_NOP         = 4'd0,
    OP_NV2W        = 4'd1,
    OP_W2NV        = 4'd2,
    OP_D2NV        = 4'd3,
    OP_SHR         = 4'd4,
    OP_SHR_ALL     = 4'd5,
    OP_DEC         = 4'd6,
    OP_DEC_ALL     = 4'd7,
    OP_RESTORE_ALL = 4'd8,
    OP_RD_NV       = 4'd9,
    OP_RD_W        = 4'd10,
    OP_D2W         = 4'd11,
    OP_SHL         = 4'd12,
    OP_SHL_ALL     = 4'd13,
    OP_INC         = 4'd14,
    OP_INC_ALL     = 4'd15
  } op_e;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_LOAD_DATA,
    ACT_LOAD_NV,
    ACT_INC,
    ACT_DEC,
    ACT_SHL,
    ACT_SHR
  } act_e;
endpackage

// File: rtl/wpot_cmd_decode.sv
module wpot_cmd_decode
  import wpot_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 4,
  parameter int CW  = 1
) (
  input  logic            accept_i,
  input  logic [3:0]      op_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wp_ni,
  output act_e            act_o,
  output logic [NCH-1:0]  mask_o,
  output logic            nv_we_o,
  output logic            nv_src_data_o,
  output logic            rd_en_o,
  output logic            rd_src_nv_o,
  output logic [CW-1:0]   idx_o
);
  op_e              op;
  act_e             act_raw;
  logic             all_ch;
  logic             guarded;
  logic             addr_ok;
  logic             go;
  logic [NCH-1:0]   hit;

  assign op      = op_e'(op_i);
  assign addr_ok = 32'(addr_i) < 32'(NCH);

  for (genvar c = 0; c < NCH; c++) begin : g_hit
    assign hit[c] = (32'(addr_i) == c);
  end

  always_comb begin
    act_raw = ACT_HOLD;
    all_ch  = 1'b0;
    guarded = 1'b1;
    case (op)
      OP_NOP:         guarded = 1'b0;
      OP_NV2W:        begin act_raw = ACT_LOAD_NV; guarded = 1'b0; end
      OP_W2NV:        act_raw = ACT_HOLD;
      OP_D2NV:        act_raw = ACT_HOLD;
      OP_SHR:         act_raw = ACT_SHR;
      OP_SHR_ALL:     begin act_raw = ACT_SHR; all_ch = 1'b1; end
      OP_DEC:         act_raw = ACT_DEC;
      OP_DEC_ALL:     begin act_raw = ACT_DEC; all_ch = 1'b1; end
      OP_RESTORE_ALL: begin act_raw = ACT_LOAD_NV; all_ch = 1'b1; guarded = 1'b0; end
      OP_RD_NV:       guarded = 1'b0;
      OP_RD_W:        guarded = 1'b0;
      OP_D2W:         act_raw = ACT_LOAD_DATA;
      OP_SHL:         act_raw = ACT_SHL;
      OP_SHL_ALL:     begin act_raw = ACT_SHL; all_ch = 1'b1; end
      OP_INC:         act_raw = ACT_INC;
      OP_INC_ALL:     begin act_raw = ACT_INC; all_ch = 1'b1; end
      default:        act_raw = ACT_HOLD;
    endcase
  end

  // protected opcodes are dropped entirely under write protect
  assign go            = accept_i & (wp_ni | ~guarded);
  assign act_o         = go ? act_raw : ACT_HOLD;
  assign mask_o        = !go ? '0 : (all_ch ? '1 : hit);
  assign nv_we_o       = go & addr_ok & ((op == OP_W2NV) | (op == OP_D2NV));
  assign nv_src_data_o = (op == OP_D2NV);
  assign rd_en_o       = go & addr_ok & ((op == OP_RD_NV) | (op == OP_RD_W));
  assign rd_src_nv_o   = (op == OP_RD_NV);
  assign idx_o         = addr_i[CW-1:0];
endmodule

// File: rtl/wpot_step.sv
module wpot_step
  import wpot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] nv_i,
  input  act_e         act_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ZERO = '0;

  always_comb begin
    case (act_i)
      ACT_LOAD_DATA: nxt_o = data_i;
      ACT_LOAD_NV:   nxt_o = nv_i;
      ACT_INC:       nxt_o = (cur_i == ONES) ? ONES : cur_i + W'(1);
      ACT_DEC:       nxt_o = (cur_i == ZERO) ? ZERO : cur_i - W'(1);
      ACT_SHL:       nxt_o = cur_i[W-1] ? ONES : {cur_i[W-2:0], 1'b1};
      ACT_SHR:       nxt_o = {1'b0, cur_i[W-1:1]};
      default:       nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/wpot_chan.sv
module wpot_chan
  import wpot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         force_mid_i,
  input  logic         reload_i,
  input  logic         en_i,
  input  act_e         act_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] nv_i,
  output logic [W-1:0] wiper_o
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] wiper_q;
  logic [W-1:0] nxt;

  wpot_step #(.W(W)) u_step (
    .cur_i  (wiper_q),
    .data_i (data_i),
    .nv_i   (nv_i),
    .act_i  (act_i),
    .nxt_o  (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wiper_q <= '0;
    else if (force_mid_i) wiper_q <= MID;
    else if (reload_i)    wiper_q <= nv_i;
    else if (en_i)        wiper_q <= nxt;
  end

  assign wiper_o = wiper_q;
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wpot_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 8,
  parameter int AW  = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [3:0]       cmd_op_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [W-1:0]     cmd_data_i,
  input  logic [NCH*W-1:0] nv_rdata_i,
  input  logic             preset_ni,
  input  logic             wp_ni,
  output logic             nv_we_o,
  output logic [CW-1:0]    nv_waddr_o,
  output logic [W-1:0]     nv_wdata_o,
  output logic [NCH*W-1:0] wiper_o,
  output logic [W-1:0]     rdback_o,
  output logic             valid_o
);
  logic             ready_q;
  logic             preset_q;
  logic [W-1:0]     rd_q;
  logic             accept;
  logic             reload;
  logic             force_mid;
  act_e             act;
  logic [NCH-1:0]   ch_mask;
  logic             nv_we;
  logic             nv_src_data;
  logic             rd_en;
  logic             rd_src_nv;
  logic [CW-1:0]    ch_idx;
  logic [W-1:0]     wip    [NCH];
  logic [W-1:0]     nv_arr [NCH];

  // commands only on settled cycles: loaded, preset high now and last edge
  assign accept    = cmd_valid_i & ready_q & preset_ni & preset_q;
  assign reload    = ~ready_q | (preset_ni & ~preset_q);
  assign force_mid = ~preset_ni;

  wpot_cmd_decode #(.NCH(NCH), .AW(AW), .CW(CW)) u_dec (
    .accept_i      (accept),
    .op_i          (cmd_op_i),
    .addr_i        (cmd_addr_i),
    .wp_ni         (wp_ni),
    .act_o         (act),
    .mask_o        (ch_mask),
    .nv_we_o       (nv_we),
    .nv_src_data_o (nv_src_data),
    .rd_en_o       (rd_en),
    .rd_src_nv_o   (rd_src_nv),
    .idx_o         (ch_idx)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign nv_arr[c] = nv_rdata_i[c*W +: W];

    wpot_chan #(.W(W)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .force_mid_i (force_mid),
      .reload_i    (reload),
      .en_i        (ch_mask[c]),
      .act_i       (act),
      .data_i      (cmd_data_i),
      .nv_i        (nv_arr[c]),
      .wiper_o     (wip[c])
    );

    assign wiper_o[c*W +: W] = wip[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q  <= 1'b0;
      preset_q <= 1'b1;
      rd_q     <= '0;
    end else begin
      ready_q  <= 1'b1;
      preset_q <= preset_ni;
      if (rd_en) rd_q <= rd_src_nv ? nv_arr[ch_idx] : wip[ch_idx];
    end
  end

  assign nv_we_o    = nv_we;
  assign nv_waddr_o = ch_idx;
  assign nv_wdata_o = nv_src_data ? cmd_data_i : wip[ch_idx];
  assign rdback_o   = rd_q;
  assign valid_o    = ready_q;
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int NCH = 2,
  parameter int W   = 8,
  parameter int AW  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [3:0]       cmd_op_i,
  input logic [AW-1:0]    cmd_addr_i,
  input logic             preset_ni,
  input logic             wp_ni,
  input logic             nv_we_o,
  input logic [NCH*W-1:0] wiper_o,
  input logic             valid_o
);
  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = '1;

  logic acc;
  logic modifying;
  assign acc       = cmd_valid_i & valid_o & preset_ni;
  assign modifying = (cmd_op_i >= 4'd4 && cmd_op_i <= 4'd7) || (cmd_op_i >= 4'd11);

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o); // R1

  AST_PRESET_MIDSCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preset_ni |=> (wiper_o == {NCH{MID}})); // R11

  AST_WP_NO_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |-> !nv_we_o); // R12

  AST_WP_WIPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && $past(preset_ni) && !wp_ni && modifying) |=> $stable(wiper_o)); // R12

  AST_DEC_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && $past(preset_ni) && cmd_op_i == 4'd6 && cmd_addr_i == '0 && wiper_o[W-1:0] == '0)
    |=> (wiper_o[W-1:0] == '0)); // R3

  AST_INC_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && $past(preset_ni) && cmd_op_i == 4'd14 && cmd_addr_i == '0 && wiper_o[W-1:0] == ONES)
    |=> (wiper_o[W-1:0] == ONES)); // R3

  AST_STORE_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nv_we_o |-> (cmd_valid_i && valid_o && preset_ni)); // R7
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.NCH(NCH), .W(W), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_addr_i  (cmd_addr_i),
  .preset_ni   (preset_ni),
  .wp_ni       (wp_ni),
  .nv_we_o     (nv_we_o),
  .wiper_o     (wiper_o),
  .valid_o     (valid_o)
);

// File: tb/wiper_ctrl_tb.sv
`timescale 1ns/1ps
module wiper_ctrl_tb;
  localparam int NCH = 2;
  localparam int W   = 8;
  localparam int AW  = 4;
  localparam int CW  = 1;
  localparam int MID = 128;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cmd_valid;
  logic [3:0]       cmd_op;
  logic [AW-1:0]    cmd_addr;
  logic [W-1:0]     cmd_data;
  logic [NCH*W-1:0] nv_rdata;
  logic             preset_n;
  logic             wp_n;
  logic             nv_we;
  logic [CW-1:0]    nv_waddr;
  logic [W-1:0]     nv_wdata;
  logic [NCH*W-1:0] wiper;
  logic [W-1:0]     rdback;
  logic             valid;

  int mem [NCH];
  int mw  [NCH];
  int mrd;
  bit mvalid;
  bit mprev;
  int errs   = 0;
  int checks = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) nv_rdata[c*W +: W] = mem[c][W-1:0];

  wiper_ctrl #(.NCH(NCH), .W(W), .AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .nv_rdata_i(nv_rdata),
    .preset_ni(preset_n), .wp_ni(wp_n), .nv_we_o(nv_we), .nv_waddr_o(nv_waddr),
    .nv_wdata_o(nv_wdata), .wiper_o(wiper), .rdback_o(rdback), .valid_o(valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int f_inc(int v); return (v == 255) ? 255 : v + 1; endfunction
  function automatic int f_dec(int v); return (v == 0) ? 0 : v - 1; endfunction
  function automatic int f_shl(int v); return (v >= 128) ? 255 : v * 2 + 1; endfunction
  function automatic int f_shr(int v); return v / 2; endfunction

  task automatic check_outs(input string tag);
    for (int c = 0; c < NCH; c++) chk({tag, " wiper"}, int'(wiper[c*W +: W]), mw[c]);
    chk({tag, " rdback"}, int'(rdback), mrd);
    chk({tag, " valid"}, int'(valid), int'(mvalid));
  endtask

  task automatic cyc(input string tag, input bit v, input int op, input int addr,
                     input int data, input bit pn = 1'b1, input bit wpn = 1'b1);
    bit acc, aok, prot, go, ewe;
    int ewd;
    int old [NCH];
    cmd_valid = v; cmd_op = op[3:0]; cmd_addr = addr[AW-1:0];
    cmd_data = data[W-1:0]; preset_n = pn; wp_n = wpn;
    #1;
    acc  = v && mvalid && pn && mprev;
    aok  = addr < NCH;
    prot = !(op == 0 || op == 1 || op == 8 || op == 9 || op == 10);
    go   = acc && (wpn || !prot);
    ewe  = go && aok && (op == 2 || op == 3);
    ewd  = (op == 3) ? (data & 255) : (aok ? mw[addr] : 0);
    chk({tag, " R7 nv_we"}, int'(nv_we), int'(ewe));
    if (ewe) begin
      chk({tag, " R7 nv_waddr"}, int'(nv_waddr), addr);
      chk({tag, " R7 nv_wdata"}, int'(nv_wdata), ewd);
    end
    @(posedge clk);
    old = mw;
    if (!pn) begin
      for (int c = 0; c < NCH; c++) mw[c] = MID;
    end else if (!mvalid || !mprev) begin
      for (int c = 0; c < NCH; c++) mw[c] = mem[c];
    end else if (go) begin
      case (op)
        1:  if (aok) mw[addr] = mem[addr];
        4:  if (aok) mw[addr] = f_shr(old[addr]);
        5:  for (int c = 0; c < NCH; c++) mw[c] = f_shr(old[c]);
        6:  if (aok) mw[addr] = f_dec(old[addr]);
        7:  for (int c = 0; c < NCH; c++) mw[c] = f_dec(old[c]);
        8:  for (int c = 0; c < NCH; c++) mw[c] = mem[c];
        11: if (aok) mw[addr] = data & 255;
        12: if (aok) mw[addr] = f_shl(old[addr]);
        13: for (int c = 0; c < NCH; c++) mw[c] = f_shl(old[c]);
        14: if (aok) mw[addr] = f_inc(old[addr]);
        15: for (int c = 0; c < NCH; c++) mw[c] = f_inc(old[c]);
        default: ;
      endcase
      if (aok && op == 9)  mrd = mem[addr];
      if (aok && op == 10) mrd = old[addr];
    end
    mprev  = pn;
    mvalid = 1'b1;
    #1;
    if (ewe) mem[addr] = ewd;
    @(negedge clk);
    check_outs(tag);
  endtask

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    mem[0] = 8'h80; mem[1] = 8'h5A;
    for (int c = 0; c < NCH; c++) mw[c] = 0;
    mrd = 0; mvalid = 0; mprev = 1;
    rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_data = 0;
    preset_n = 1; wp_n = 1;
    repeat (3) @(negedge clk);
    check_outs("R1 reset");
    rst_n = 1;
    // command in the load cycle is ignored
    cyc("R1 load", 1, 11, 0, 8'h11);
    cyc("R1 hold", 0, 0, 0, 0);

    cyc("R2 load ch0", 1, 11, 0, 8'h12);
    cyc("R2 load ch1", 1, 11, 1, 8'hFE);
    cyc("R3 inc ch1", 1, 14, 1, 8'h00);
    cyc("R3 inc sat", 1, 14, 1, 8'h00);
    cyc("R3 inc sat2", 1, 14, 1, 8'h33);
    cyc("R2 load ch0 one", 1, 11, 0, 1);
    cyc("R3 dec ch0", 1, 6, 0, 8'hFF);
    cyc("R3 dec floor", 1, 6, 0, 8'hFF);
    for (int i = 0; i < 9; i++) cyc("R4 shl chain", 1, 12, 0, 8'hA5);
    cyc("R2 load 0x40", 1, 11, 0, 8'h40);
    cyc("R4 shl 0x40", 1, 12, 0, 0);
    cyc("R4 shl clamp", 1, 12, 0, 0);
    for (int i = 0; i < 9; i++) cyc("R4 shr chain", 1, 4, 0, 8'hFF);
    cyc("R6 shr ignores data", 1, 4, 1, 8'h00);
    cyc("R5 inc all", 1, 15, 3, 8'h77);
    cyc("R5 shl all", 1, 13, 9, 0);
    cyc("R5 dec all", 1, 7, 2, 0);
    cyc("R5 shr all", 1, 5, 15, 0);
    cyc("R10 bad addr load", 1, 11, 2, 8'h44);
    cyc("R10 bad addr inc", 1, 14, 15, 0);
    cyc("R10 bad addr store", 1, 3, 7, 8'h44);
    cyc("R10 bad addr read", 1, 10, 2, 0);
    cyc("R10 nop", 1, 0, 0, 8'h99);
    cyc("R2 load ch0", 1, 11, 0, 8'hC3);
    cyc("R7 wiper to store", 1, 2, 0, 0);
    cyc("R7 data to store", 1, 3, 1, 8'h33);
    cyc("R9 read store", 1, 9, 1, 0);
    cyc("R9 read wiper", 1, 10, 0, 0);
    cyc("R9 other op keeps", 1, 14, 1, 0);
    cyc("R8 restore ch1", 1, 1, 1, 0);
    cyc("R2 scramble", 1, 11, 0, 8'h07);
    cyc("R8 restore all", 1, 8, 0, 0);
    for (int op = 0; op < 16; op++) cyc("R12 protect", 1, op, op % 2, 8'h5C, 1, 0);
    cyc("R11 preset low", 1, 11, 0, 8'h01, 0, 1);
    cyc("R11 preset low cmd", 1, 14, 1, 0, 0, 1);
    cyc("R11 preset rise", 1, 11, 0, 8'h02, 1, 1);
    cyc("R11 after rise", 1, 11, 0, 8'h03, 1, 1);
    for (int i = 0; i < 3000; i++)
      cyc("R6 random", $urandom_range(0, 4) != 0, $urandom_range(0, 15),
          $urandom_range(0, 3), $urandom_range(0, 255),
          $urandom_range(0, 15) != 0, $urandom_range(0, 7) != 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule